// File: doc/BRIEF.md
# Iterative Early-Terminating Booth Multiplier

This block is a multi-cycle integer multiplier for a processor execute stage. It forms the low 32 bits of `op_m * op_s`, and can add `op_n` to the product in the same operation. The multiplier operand `op_s` is recoded two bits at a time with radix-4 Booth digits, and one digit is handled per clock. The block stops as soon as the bits of `op_s` not yet examined can no longer change the product. The cycle count therefore depends on the value of `op_s`, so swapping the two operands can shorten or lengthen an operation.

An operation is launched by a one-cycle `start` while the block is idle. The operands and the two mode bits are captured on that edge. `busy` stays high for one setup cycle plus one cycle per Booth digit. Then `done` pulses for a single cycle, and the new `result` appears together with it. The handshake is plain control, with no back-pressure. The block accepts a launch whenever `busy` is low. A `start` that arrives while `busy` is high is dropped, and the caller must wait for `done` before it launches again. When flag update was requested at launch, the negative and zero flags are refreshed from the result at completion. Otherwise they keep their old values.

Top module: `booth_iter_mul`

## Requirements
- R1: When `done` is high, `result` equals (`op_m` * `op_s` + (`acc_en` ? `op_n` : 0)) mod 2^32, using the values captured at launch. The same value holds whether the operands are read as signed or unsigned.
- R2: For `op_s` with bit 31 clear, let h be the index of its highest set bit and P = min(16, floor((h+1)/2) + 1). `done` is high in the cycle that starts at the (1+P)-th rising edge after the launch edge, and `busy` is high in every cycle before it.
- R3: `done` is high for exactly one cycle per operation, and `busy` is low in that cycle.
- R4: A `start` while `busy` is high is ignored. Changes on `op_m`, `op_s`, `op_n`, `acc_en` and `flag_en` after the launch edge do not affect the running operation.
- R5: If `flag_en` was high at launch, then at completion `flag_n` equals bit 31 of the result and `flag_z` is 1 exactly when the result is zero.
- R6: If `flag_en` was low at launch, `flag_n` and `flag_z` keep their previous values through the operation.
- R7: `result` changes only on the edge that raises `done`, and holds its value in every other cycle.
- R8: After reset, `busy`, `done`, `result`, `flag_n` and `flag_z` are all zero.
- R9: With `op_s` = 0 the operation takes 1 cycle, and `result` is `op_n` when accumulating and 0 otherwise.
- R10: With bit 31 of `op_s` set, all 16 digits are processed and the operation takes 17 cycles.
- R11: The accumulate addend costs no cycle: the latency is the same with `acc_en` high or low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch pulse, taken only while idle |
| op_m | input | 32 | Multiplicand |
| op_s | input | 32 | Multiplier; its value sets the latency |
| op_n | input | 32 | Accumulate addend |
| acc_en | input | 1 | Add `op_n` to the product |
| flag_en | input | 1 | Update the flags at completion |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Low 32 bits of the product (plus addend) |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |

## Verification
The assertions check on every cycle the properties that do not depend on data. They cover the single-cycle `done` pulse, that `done` and `busy` are never high together, that `result` holds outside completion, that the flags hold when no update was requested and match the result when one was, and that the digit counter stays within bounds. Only the bench scenarios can show the arithmetic value and the exact latency for a given `op_s`. These include the two operand orders of 18 and -1, zero and negative multipliers, and launch attempts made in the middle of an operation.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_RUN   = 2'd2
  } mul_state_e;

  // One radix-4 Booth digit: magnitude one or two, optionally negated.
  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } booth_dig_t;

endpackage

// File: rtl/booth_mul_recode.sv
module booth_mul_recode
  import booth_mul_pkg::*;
(
  input  logic [2:0] tri_bits,   // {b(2k+1), b(2k), b(2k-1)}
  output booth_dig_t dig
);

  always_comb begin
    dig = '0;
    unique case (tri_bits)
      3'b000, 3'b111: dig = '0;
      3'b001, 3'b010: dig.one = 1'b1;
      3'b011:         dig.two = 1'b1;
      3'b100:         begin dig.two = 1'b1; dig.neg = 1'b1; end
      3'b101, 3'b110: begin dig.one = 1'b1; dig.neg = 1'b1; end
      default:        dig = '0;
    endcase
  end

endmodule

// File: rtl/booth_mul_addend.sv
module booth_mul_addend
  import booth_mul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] mcand,
  input  booth_dig_t   dig,
  output logic [W-1:0] addend,
  output logic         carry_in
);

  logic [W-1:0] mag;

  always_comb begin
    if (dig.two)      mag = {mcand[W-2:0], 1'b0};
    else if (dig.one) mag = mcand;
    else              mag = '0;
    // Negation as one's complement here plus a carry into the adder.
    addend   = dig.neg ? ~mag : mag;
    carry_in = dig.neg;
  end

endmodule

// File: rtl/booth_iter_mul.sv
module booth_iter_mul
  import booth_mul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] op_m,
  input  logic [W-1:0] op_s,
  input  logic [W-1:0] op_n,
  input  logic         acc_en,
  input  logic         flag_en,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result,
  output logic         flag_n,
  output logic         flag_z
);

  localparam int PAIRS = W / 2;
  localparam int CW    = $clog2(PAIRS + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(PAIRS - 1);

  mul_state_e   state;
  logic [W-1:0] acc;
  logic [W-1:0] mc;
  logic [W:0]   mr;        // remaining multiplier bits, bit 0 = last examined bit
  logic [CW-1:0] cnt;
  logic         fl_q;
  logic [W-1:0] res_q;
  logic         done_q;
  logic         fn_q, fz_q;

  booth_dig_t   dig;
  logic [W-1:0] addend;
  logic         cin;
  logic [W-1:0] acc_sum;
  logic [W:0]   mr_nxt;
  logic         last_pair;

  booth_mul_recode u_recode (
    .tri_bits (mr[2:0]),
    .dig      (dig)
  );

  booth_mul_addend #(.W(W)) u_addend (
    .mcand    (mc),
    .dig      (dig),
    .addend   (addend),
    .carry_in (cin)
  );

  always_comb begin
    acc_sum   = acc + addend + {{(W-1){1'b0}}, cin};
    mr_nxt    = mr >> 2;
    last_pair = (mr_nxt == '0) || (cnt == LAST_CNT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      acc    <= '0;
      mc     <= '0;
      mr     <= '0;
      cnt    <= '0;
      fl_q   <= 1'b0;
      res_q  <= '0;
      done_q <= 1'b0;
      fn_q   <= 1'b0;
      fz_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            acc   <= acc_en ? op_n : '0;   // addend seeds the partial sum
            mc    <= op_m;
            mr    <= {op_s, 1'b0};
            cnt   <= '0;
            fl_q  <= flag_en;
            state <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (mr == '0) begin
            res_q  <= acc;
            done_q <= 1'b1;
            if (fl_q) begin
              fn_q <= acc[W-1];
              fz_q <= (acc == '0);
            end
            state <= ST_IDLE;
          end else begin
            state <= ST_RUN;
          end
        end
        ST_RUN: begin
          acc <= acc_sum;
          mc  <= {mc[W-3:0], 2'b00};
          mr  <= mr_nxt;
          cnt <= cnt + 1'b1;
          if (last_pair) begin
            res_q  <= acc_sum;
            done_q <= 1'b1;
            if (fl_q) begin
              fn_q <= acc_sum[W-1];
              fz_q <= (acc_sum == '0);
            end
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (state != ST_IDLE);
  assign done   = done_q;
  assign result = res_q;
  assign flag_n = fn_q;
  assign flag_z = fz_q;

  // Assertions
  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_not_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  p_flags_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!done || !fl_q) |-> $stable({flag_n, flag_z}));

  p_flags_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fl_q) |-> ((flag_z == (result == '0)) && (flag_n == result[W-1])));

  p_digit_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |-> (cnt < CW'(PAIRS)));

  p_launch_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  p_digit_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dig.one, dig.two}));

endmodule

// File: tb/booth_iter_mul_bench.sv
`timescale 1ns/1ps
module booth_iter_mul_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] op_m, op_s, op_n;
  logic        acc_en, flag_en;
  logic        busy, done;
  logic [31:0] result;
  logic        flag_n, flag_z;

  int n_chk = 0;
  int n_bad = 0;
  logic exp_fn = 1'b0;
  logic exp_fz = 1'b0;

  always #2 clk = ~clk;

  booth_iter_mul u_booth_iter_mul (
    .clk(clk), .rst_n(rst_n), .start(start),
    .op_m(op_m), .op_s(op_s), .op_n(op_n),
    .acc_en(acc_en), .flag_en(flag_en),
    .busy(busy), .done(done), .result(result),
    .flag_n(flag_n), .flag_z(flag_z)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_pairs(input logic [31:0] s);
    int h;
    int p;
    if (s[31]) return 16;
    if (s == 0) return 0;
    h = 0;
    for (int i = 0; i < 32; i++) if (s[i]) h = i;
    p = (h + 1) / 2 + 1;
    if (p > 16) p = 16;
    return p;
  endfunction

  function automatic logic [31:0] exp_res(input logic [31:0] m, s, n, input bit ac);
    return m * s + (ac ? n : 32'd0);
  endfunction

  // Runs one operation; returns the observed latency in cycles.
  task automatic run_op(input logic [31:0] m, s, n, input bit ac, fl, poke,
                        output int lat);
    int k;
    logic [31:0] er;
    logic [31:0] held;
    string lreq;
    er = exp_res(m, s, n, ac);
    @(negedge clk);
    start = 1'b1; op_m = m; op_s = s; op_n = n; acc_en = ac; flag_en = fl;
    @(negedge clk);
    start = 1'b0;
    op_m = $urandom; op_s = $urandom; op_n = $urandom;
    acc_en = ~ac; flag_en = ~fl;                   // R4: late input changes
    check(busy == 1'b1, "R2", "busy after launch", {31'd0, busy}, 32'd1);
    k = 0;
    do begin
      @(negedge clk);
      k++;
      if (poke && k == 1) begin
        start = 1'b1; op_m = $urandom; op_s = $urandom;   // R4: start while busy
      end else begin
        start = 1'b0;
      end
    end while (!done && k < 40);
    lat = k;
    lreq = (s == 0) ? "R9" : (s[31] ? "R10" : "R2");
    check(k == 1 + exp_pairs(s), lreq, "latency", k, 1 + exp_pairs(s));
    check(result == er, poke ? "R4" : ((s == 0) ? "R9" : "R1"), "result", result, er);
    check(busy == 1'b0, "R3", "busy with done", {31'd0, busy}, 32'd0);
    if (fl) begin
      exp_fn = er[31];
      exp_fz = (er == 0);
    end
    check(flag_n == exp_fn && flag_z == exp_fz, fl ? "R5" : "R6", "flags",
          {30'd0, flag_n, flag_z}, {30'd0, exp_fn, exp_fz});
    held = result;
    op_m = $urandom; op_s = $urandom;
    @(negedge clk);
    check(done == 1'b0, "R3", "done pulse width", {31'd0, done}, 32'd0);
    @(negedge clk);
    check(result == held, "R7", "result hold", result, held);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int lat, lat2;
    logic [31:0] s;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; start = 1'b0;
    op_m = '0; op_s = '0; op_n = '0; acc_en = 1'b0; flag_en = 1'b0;
    repeat (3) @(negedge clk);
    check({busy, done, flag_n, flag_z} == 4'b0 && result == 0, "R8", "reset state",
          {27'd0, busy, done, flag_n, flag_z, |result}, 32'd0);
    rst_n = 1'b1;

    // Operand order: multiplier 18 is short, multiplier -1 is long.
    run_op(32'hFFFF_FFFF, 32'd18, 32'd0, 1'b0, 1'b1, 1'b0, lat);
    check(lat == 4, "R2", "18 as multiplier", lat, 4);
    run_op(32'd18, 32'hFFFF_FFFF, 32'd0, 1'b0, 1'b1, 1'b0, lat);
    check(lat == 17, "R10", "-1 as multiplier", lat, 17);
    // Zero multiplier, with and without accumulate.
    run_op(32'h1234_5678, 32'd0, 32'hCAFE_0001, 1'b1, 1'b1, 1'b0, lat);
    run_op(32'h1234_5678, 32'd0, 32'hCAFE_0001, 1'b0, 1'b1, 1'b0, lat);
    // Zero result sets Z, then a flag-free operation keeps it.
    run_op(32'd5, 32'd3, 32'hFFFF_FFF1, 1'b1, 1'b1, 1'b0, lat);
    run_op(32'd7, 32'd9, 32'd0, 1'b0, 1'b0, 1'b0, lat);
    // Accumulate adds no cycle.
    run_op(32'h0000_0F0F, 32'h0000_3A5C, 32'd0, 1'b0, 1'b0, 1'b0, lat);
    run_op(32'h0000_0F0F, 32'h0000_3A5C, 32'h7777_0000, 1'b1, 1'b0, 1'b0, lat2);
    check(lat == lat2, "R11", "accumulate latency", lat2, lat);
    // Multiplier of odd highest bit, largest positive, most negative.
    run_op(32'hABCD_0123, 32'd2, 32'd0, 1'b0, 1'b1, 1'b0, lat);
    run_op(32'h8000_0001, 32'h7FFF_FFFF, 32'd1, 1'b1, 1'b1, 1'b1, lat);
    run_op(32'h0000_0003, 32'h8000_0000, 32'd0, 1'b0, 1'b1, 1'b1, lat);

    for (int i = 0; i < 400; i++) begin
      s = 32'($urandom) >> ($urandom % 33);
      if ($urandom % 4 == 0) s = ~s;
      run_op($urandom, s, $urandom, 1'($urandom), 1'($urandom),
             (exp_pairs(s) >= 2) && ($urandom % 3 == 0), lat);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule